// File: doc/BRIEF.md
# Dual-IO Serial Flash Fast-Read Responder

This block models the device side of a serial flash that answers a single instruction: the fast read that moves address and data two bits per serial clock. It watches an active-low chip select, the serial clock and two data lines. It collects an 8-bit opcode on line 0, then a 24-bit address two bits per clock. It lets four dummy clocks pass, and then sends bytes from a small internal array two bits per clock until chip select goes high. If the opcode is anything else, the block stays silent until the transaction ends.

The serial pins are sampled by a system clock `clk`. That clock must run at least four times faster than the serial clock, and the serial inputs must already be synchronous to it. Each data line is split into an input, an output value and an output enable, and the pad logic outside the block joins them. The array holds `2**AW` bytes. A synchronous write port loads it while chip select is high. Only the low `AW` address bits are used, so a continuous read wraps from the top location back to location zero. Both idle levels of the serial clock (mode 0 and mode 3) are accepted, because only rising and falling transitions are counted.

Top module: `dualio_read_responder`

## Requirements
- R1: A falling edge of `cs_n` restarts the instruction sequence from its first bit, and both lines stay released (`sio_oe` = 2'b00) through the opcode, address and dummy phases.
- R2: The opcode is taken from `sio_in[0]` on 8 rising `sck` edges, most significant bit first. The value 0xBB selects the dual read.
- R3: The address is taken over 12 rising `sck` edges, most significant pair first. At each edge `sio_in[1]` supplies the odd bit and `sio_in[0]` the even bit. Only address bits [AW-1:0] select the array location.
- R4: The values on both input lines during the 4 dummy rising edges have no effect on the data returned.
- R5: Driving starts at the first falling `sck` edge after the fourth dummy rising edge, with `sio_oe` = 2'b11. Each later falling edge presents the next pair. `sio_out[1]` carries D7, D5, D3, D1 and `sio_out[0]` carries D6, D4, D2, D0, in that order.
- R6: After every byte the location advances by one. The location after 2**AW-1 is 0.
- R7: Bytes stream without limit while `cs_n` stays low. When `cs_n` goes high, `sio_oe` becomes 2'b00 in the same instant, without waiting for a `clk` edge.
- R8: After any opcode other than 0xBB, `sio_oe` stays 2'b00 for every later serial clock until `cs_n` goes high.
- R9: A write on the backdoor port (`wr_en` high at a `clk` rising edge) stores `wr_data` at `wr_addr` only while `cs_n` is high. While `cs_n` is low the write is discarded.
- R10: A transaction returns the same data whether `sck` idles low (mode 0) or high (mode 3) when `cs_n` falls.
- R11: While `rst_n` is low and after it is released, both lines are released until a dual read reaches its data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| sio_in | input | 2 | Values seen on data lines 1 and 0 |
| sio_out | output | 2 | Values driven onto data lines 1 and 0 |
| sio_oe | output | 2 | Output enables for data lines 1 and 0 |
| wr_en | input | 1 | Backdoor write strobe |
| wr_addr | input | AW | Backdoor write location |
| wr_data | input | 8 | Backdoor write byte |

## Verification
On every cycle the assertions check the following. The lines are never enabled outside the data phase. Driving only begins on a serial falling edge. A chip-select start or release always drops the drive. The dummy count never passes four. An unknown opcode keeps the block idle until chip select rises. The location steps by exactly one for each byte. Other behaviour only the bench's scenarios can show: the correct byte values, pair order and bit assignment, dropping of the high address bits, wrap across the array top during one long read, mode 3 handling, and the discarding of writes made while chip select is low.

// File: rtl/dualio_pkg.sv
package dualio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_OPC    = 3'd1,
    PH_ADDR   = 3'd2,
    PH_DUMMY  = 3'd3,
    PH_DATA   = 3'd4,
    PH_IGNORE = 3'd5
  } phase_t;

  localparam logic [7:0] OPC_DUAL_READ = 8'hBB;
  localparam int OPC_BITS   = 8;
  localparam int ADDR_BITS  = 24;
  localparam int ADDR_EDGES = ADDR_BITS / 2;
  localparam int DUMMY_EDGES = 4;
  localparam int PAIRS_PER_BYTE = 4;

endpackage

// File: rtl/dualio_edges.sv
module dualio_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_begin
);

  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
  assign cs_begin = ~cs_n & cs_q;

endmodule

// File: rtl/dualio_mem.sv
module dualio_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      arr[wa] <= wd;
    end
  end

  assign rd = arr[ra];

endmodule

// File: rtl/dualio_seq.sv
module dualio_seq
  import dualio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs_begin,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic [1:0]    sio_in,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    pair_out,
  output logic          drive
);

  localparam int CW = $clog2(ADDR_EDGES);

  phase_t          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [7:0]      op_q, op_d;
  logic [23:0]     addr_q, addr_d;
  logic [AW-1:0]   ptr_q, ptr_d;
  logic [1:0]      pc_q, pc_d;
  logic [5:0]      sh_q, sh_d;
  logic [1:0]      out_q, out_d;
  logic            drv_q, drv_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    addr_d  = addr_q;
    ptr_d   = ptr_q;
    pc_d    = pc_q;
    sh_d    = sh_q;
    out_d   = out_q;
    drv_d   = drv_q;
    if (cs_n) begin
      phase_d = PH_IDLE;
      drv_d   = 1'b0;
    end else if (cs_begin) begin
      phase_d = PH_OPC;
      cnt_d   = '0;
      drv_d   = 1'b0;
    end else begin
      case (phase_q)
        PH_OPC: begin
          if (sck_rise) begin
            op_d = {op_q[6:0], sio_in[0]};
            if (cnt_q == CW'(OPC_BITS - 1)) begin
              cnt_d   = '0;
              phase_d = (op_d == OPC_DUAL_READ) ? PH_ADDR : PH_IGNORE;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        PH_ADDR: begin
          if (sck_rise) begin
            addr_d = {addr_q[21:0], sio_in[1], sio_in[0]};
            if (cnt_q == CW'(ADDR_EDGES - 1)) begin
              cnt_d   = '0;
              ptr_d   = addr_d[AW-1:0];
              phase_d = PH_DUMMY;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        PH_DUMMY: begin
          if (sck_rise) begin
            if (cnt_q == CW'(DUMMY_EDGES - 1)) begin
              cnt_d   = '0;
              pc_d    = '0;
              phase_d = PH_DATA;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        PH_DATA: begin
          if (sck_fall) begin
            drv_d = 1'b1;
            pc_d  = pc_q + 2'd1;
            if (pc_q == 2'd0) begin
              out_d = rd_data[7:6];
              sh_d  = rd_data[5:0];
              ptr_d = ptr_q + AW'(1);
            end else begin
              out_d = sh_q[5:4];
              sh_d  = {sh_q[3:0], 2'b00};
            end
          end
        end
        default: begin
          phase_d = phase_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      ptr_q   <= '0;
      pc_q    <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      drv_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      ptr_q   <= ptr_d;
      pc_q    <= pc_d;
      sh_q    <= sh_d;
      out_q   <= out_d;
      drv_q   <= drv_d;
    end
  end

  assign rd_addr  = ptr_q;
  assign pair_out = out_q;
  assign drive    = drv_q;

  // R1: a new transaction always starts with the lines released
  a_r1_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    cs_begin |=> !drv_q);

  // R7: chip select high clears the drive state at the next edge
  a_r7_drop_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !drv_q);

  // R5: drive is only ever held in the data phase
  a_r5_drive_in_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_DATA) |-> !drv_q);

  // R5: driving begins only on a serial falling edge
  a_r5_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> $past(sck_fall));

  // R4: dummy phase lasts four rising edges at most
  a_r4_dummy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DUMMY) |-> (cnt_q < CW'(DUMMY_EDGES)));

  // R8: an unknown opcode parks the sequencer until deselect
  a_r8_ignore_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IGNORE && !cs_n) |=> (phase_q == PH_IGNORE || phase_q == PH_IDLE));

  // R6: each byte fetch steps the location by one, wrapping at the top
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && sck_fall && pc_q == 2'd0 && !cs_n && !cs_begin)
      |=> (ptr_q == $past(ptr_q) + AW'(1)));

endmodule

// File: rtl/dualio_read_responder.sv
module dualio_read_responder #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic [1:0]    sio_in,
  output logic [1:0]    sio_out,
  output logic [1:0]    sio_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data
);

  logic          sck_rise;
  logic          sck_fall;
  logic          cs_begin;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic [1:0]    pair_out;
  logic          drive;
  logic          mem_we;

  dualio_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_begin (cs_begin)
  );

  assign mem_we = wr_en & cs_n;

  dualio_mem #(.AW(AW)) u_mem (
    .clk (clk),
    .we  (mem_we),
    .wa  (wr_addr),
    .wd  (wr_data),
    .ra  (rd_addr),
    .rd  (rd_data)
  );

  dualio_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cs_begin (cs_begin),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sio_in   (sio_in),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .pair_out (pair_out),
    .drive    (drive)
  );

  assign sio_out = pair_out;
  assign sio_oe  = {2{drive & ~cs_n}};

  // R11: lines stay released while the block is held in reset
  a_r11_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (sio_oe == 2'b00));

endmodule

// File: tb/tb_dualio_read_responder.sv
`timescale 1ns/1ps
module tb_dualio_read_responder;

  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          cs_n;
  logic          sck;
  logic [1:0]    sio_in;
  logic [1:0]    sio_out;
  logic [1:0]    sio_oe;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] shadow [DEPTH];

  dualio_read_responder #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sio_in(sio_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 73 + 29) ^ (i >> 3));
  endfunction

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one serial clock: falling half first, sample at the rise
  task automatic spi_cyc(input logic [1:0] d, output logic [1:0] q, output logic [1:0] oe);
    @(negedge clk);
    sck = 1'b0;
    sio_in = d;
    wait_neg(3);
    q = sio_out;
    oe = sio_oe;
    sck = 1'b1;
    wait_neg(3);
  endtask

  task automatic backdoor(input int a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = AW'(a);
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // full transaction; extra_pairs > 0 ends with a mid-byte deselect
  task automatic read_seq(input logic [7:0] opc, input logic [23:0] a, input int nb,
                          input bit m3, input int extra_pairs, input string tag);
    logic [1:0] q;
    logic [1:0] oe;
    logic [7:0] got;
    logic [7:0] exp;
    @(negedge clk);
    sck = m3;
    wait_neg(2);
    cs_n = 1'b0;
    wait_neg(3);
    for (int i = 7; i >= 0; i--) begin
      spi_cyc({1'b1, opc[i]}, q, oe);
      chk(oe == 2'b00, {tag, " R1 released in opcode"}, oe, 0);
    end
    for (int k = 11; k >= 0; k--) begin
      spi_cyc({a[2*k+1], a[2*k]}, q, oe);
      chk(oe == 2'b00, {tag, " R1 released in address"}, oe, 0);
    end
    for (int k = 0; k < 4; k++) begin
      spi_cyc(2'(k + 1), q, oe);
      chk(oe == 2'b00, {tag, " R4 R5 released in dummy"}, oe, 0);
    end
    if (opc != 8'hBB) begin
      for (int k = 0; k < nb * 4; k++) begin
        spi_cyc(2'(k), q, oe);
        chk(oe == 2'b00, {tag, " R8 silent after other opcode"}, oe, 0);
      end
    end else begin
      for (int b = 0; b < nb; b++) begin
        exp = shadow[(int'(a[AW-1:0]) + b) % DEPTH];
        got = '0;
        for (int p = 0; p < 4; p++) begin
          spi_cyc(2'b00, q, oe);
          chk(oe == 2'b11, {tag, " R5 driving in data"}, oe, 3);
          got = {got[5:0], q};
        end
        chk(got == exp, {tag, " R3 R5 R6 byte value"}, got, exp);
      end
      for (int p = 0; p < extra_pairs; p++) spi_cyc(2'b00, q, oe);
      if (extra_pairs > 0) begin
        @(negedge clk);
        chk(sio_oe == 2'b11, {tag, " R7 still driving before deselect"}, sio_oe, 3);
      end
    end
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    chk(sio_oe == 2'b00, {tag, " R7 released on deselect"}, sio_oe, 0);
    wait_neg(4);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    sck = 1'b0;
    sio_in = 2'b00;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    wait_neg(3);
    chk(sio_oe == 2'b00, "R11 released in reset", sio_oe, 0);
    rst_n = 1'b1;
    wait_neg(2);
    chk(sio_oe == 2'b00, "R11 released after reset", sio_oe, 0);

    // R9: preload the whole array through the backdoor
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = pattern(i);
      backdoor(i, pattern(i));
    end

    // R2 R3: plain reads, high address bits set to show they are dropped
    read_seq(8'hBB, 24'h000000, 3, 1'b0, 0, "base");
    read_seq(8'hBB, 24'hC3A55A, 4, 1'b0, 0, "highbits");
    // R6: short wrap across the top
    read_seq(8'hBB, 24'h0000FE, 4, 1'b0, 0, "wrap");
    // R6 R7: sweep every location in one continuous read, crossing the top
    read_seq(8'hBB, 24'h5A3C80, DEPTH + 4, 1'b0, 0, "sweep");
    // R10: mode 3 idle level
    read_seq(8'hBB, 24'h000033, 3, 1'b1, 0, "mode3");
    // R8: other opcodes stay silent
    read_seq(8'h3B, 24'h000010, 3, 1'b0, 0, "op3B");
    read_seq(8'hBA, 24'h000010, 2, 1'b1, 0, "opBA");
    // R7: deselect in mid-byte, then R1 fresh start
    read_seq(8'hBB, 24'h000040, 2, 1'b0, 2, "abort");
    read_seq(8'hBB, 24'h000041, 2, 1'b0, 0, "restart");

    // R9: write while selected is discarded
    @(negedge clk);
    cs_n = 1'b0;
    backdoor(16, ~shadow[16]);
    @(negedge clk);
    cs_n = 1'b1;
    wait_neg(3);
    read_seq(8'hBB, 24'h000010, 1, 1'b0, 0, "R9 gated write");
    // R9: write while deselected is stored
    shadow[17] = 8'h5C;
    backdoor(17, 8'h5C);
    read_seq(8'hBB, 24'h000010, 2, 1'b0, 0, "R9 open write");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule